// File: doc/BRIEF.md
# Lockable Thermal Protection Register File

This block is the control and status register file of an on-chip thermal monitor. It holds a programmable over-temperature threshold, a bit that enables the shutdown action, and a lock bit. Each request on its register bus carries an identity tag. Requester 0 is the trusted management controller, and every other tag belongs to an untrusted core. After power-on reset, trusted firmware sets the threshold and the shutdown enable, then sets the lock. From then on no requester can change either configuration register, and the lock stays set until the next system reset.

The block also compares each valid sensor sample against the threshold. When the shutdown enable is set and a sample reaches the threshold, the block raises a shutdown request. That request stays high until reset. Every bus access gets a response one cycle later. A write that the block refuses still completes, but it returns an error flag and changes nothing. Reads are open to every requester.

Top module: `thermreg_guard`

## Requirements
- R1: After reset the threshold (byte offset 0x0, bits 9:0) reads 0x3FF, the shutdown enable (offset 0x4, bit 0) reads 1, the lock (offset 0x8, bit 0) reads 0, and shutdown_req is 0.
- R2: While the lock is clear, a write from any requester to offset 0x0 loads wdata[9:0] into the threshold, and a write to offset 0x4 loads wdata[0] into the shutdown enable. Both writes return rsp_err = 0.
- R3: While the lock is set, writes to offsets 0x0 and 0x4 leave the threshold and the enable unchanged and return rsp_err = 1. This holds for every requester, including requester 0.
- R4: A write to offset 0x8 from any requester ID other than 0 returns rsp_err = 1 and does not change the lock.
- R5: The lock is write-1-to-set. A write from requester 0 to offset 0x8 with wdata[0] = 1 sets the lock. A write with wdata[0] = 0 leaves the lock unchanged. Both return rsp_err = 0.
- R6: Once set, the lock is never cleared by any bus write from any requester. Only reset clears it.
- R7: When samp_valid is high, samp_value >= threshold (unsigned) and the enable is 1, shutdown_req is high from the next clock edge onward. Equality counts as reaching the threshold.
- R8: A sample below the threshold, a sample taken while the enable is 0, or a sample value presented without samp_valid does not raise shutdown_req.
- R9: Once high, shutdown_req stays high until reset, whatever the later samples or register writes are.
- R10: Every request with req_valid high produces exactly one cycle of rsp_valid on the following cycle. Reads of offsets 0x0, 0x4 and 0x8 succeed for every requester ID, with rsp_err = 0 and the register value zero-extended on rsp_rdata.
- R11: An access to any other offset (0xC, or any address with bits 1:0 not zero) returns rsp_err = 1 and rsp_rdata = 0. It changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_id | input | 4 | Requester identity; 0 is trusted |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Access refused or unmapped |
| samp_valid | input | 1 | Sensor sample strobe |
| samp_value | input | 10 | Unsigned sensor sample |
| shutdown_req | output | 1 | Sticky over-temperature shutdown request |

## Verification
The bench first uses requester 0 to set the lock, then tries to clear it with a zero write and writes from untrusted IDs. A design that decoded the lock bit as plain read/write, or that checked the requester only on set, would unlock at this point. The bench writes both protected registers after locking, from the trusted ID as well as untrusted ones. A design that guarded only one register, or exempted the trusted ID, would let the value through. On the comparator side the bench drives a sample exactly equal to the threshold, a sample one below it, a high value without the strobe, and a trigger with the enable cleared. These cases catch a strict greater-than compare, a compare that ignores the strobe, and a compare that ignores the enable. The bench finally drives low samples after a trigger, which a non-sticky request would drop.

// File: rtl/thermreg_pkg.sv
package thermreg_pkg;

  // Register selected by a bus access
  typedef enum logic [1:0] {
    SEL_THR  = 2'd0,
    SEL_SHEN = 2'd1,
    SEL_LOCK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Word index of each mapped register (byte offset / 4)
  localparam int unsigned IDX_THR  = 0;
  localparam int unsigned IDX_SHEN = 1;
  localparam int unsigned IDX_LOCK = 2;

  // Outcome of decoding one bus access
  typedef struct packed {
    reg_sel_e sel;
    logic     thr_we;
    logic     shen_we;
    logic     lock_we;
    logic     err;
  } acc_dec_t;

endpackage

// File: rtl/thermreg_rst_sync.sv
module thermreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/thermreg_decode.sv
module thermreg_decode
  import thermreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned TRUSTED_ID = 0
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic              lock_q,
  output acc_dec_t          dec
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [ID_W-1:0] TRUSTED = ID_W'(TRUSTED_ID);

  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             trusted;
  logic             do_wr;

  assign word_idx = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign trusted  = (req_id == TRUSTED);
  assign do_wr    = req_valid & req_write;

  always_comb begin
    dec.sel     = SEL_NONE;
    dec.thr_we  = 1'b0;
    dec.shen_we = 1'b0;
    dec.lock_we = 1'b0;
    dec.err     = 1'b0;
    if (req_valid) begin
      if (!aligned) begin
        dec.err = 1'b1;
      end else if (word_idx == IDX_W'(IDX_THR)) begin
        dec.sel    = SEL_THR;
        dec.thr_we = do_wr & ~lock_q;
        dec.err    = do_wr &  lock_q;
      end else if (word_idx == IDX_W'(IDX_SHEN)) begin
        dec.sel     = SEL_SHEN;
        dec.shen_we = do_wr & ~lock_q;
        dec.err     = do_wr &  lock_q;
      end else if (word_idx == IDX_W'(IDX_LOCK)) begin
        dec.sel     = SEL_LOCK;
        dec.lock_we = do_wr &  trusted;
        dec.err     = do_wr & ~trusted;
      end else begin
        dec.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/thermreg_regs.sv
module thermreg_regs
  import thermreg_pkg::*;
#(
  parameter int unsigned TEMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_dec_t          dec,
  input  logic [TEMP_W-1:0] wr_thr,
  input  logic              wr_bit0,
  output logic [TEMP_W-1:0] thr_q,
  output logic              shen_q,
  output logic              lock_q
);

  logic [TEMP_W-1:0] thr_d;
  logic              shen_d;
  logic              lock_d;

  // Next-state: protected registers load only on a granted write,
  // lock can only go from 0 to 1 on a granted write-1.
  always_comb begin
    thr_d  = thr_q;
    shen_d = shen_q;
    lock_d = lock_q;
    if (dec.thr_we) begin
      thr_d = wr_thr;
    end
    if (dec.shen_we) begin
      shen_d = wr_bit0;
    end
    if (dec.lock_we && wr_bit0) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '1;
      shen_q <= 1'b1;
      lock_q <= 1'b0;
    end else begin
      thr_q  <= thr_d;
      shen_q <= shen_d;
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/thermreg_cmp.sv
module thermreg_cmp #(
  parameter int unsigned TEMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_value,
  input  logic [TEMP_W-1:0] thr_q,
  input  logic              shen_q,
  output logic              shutdown_req
);

  logic reached;
  logic trip;
  logic shut_q;
  logic shut_d;

  assign reached = (samp_value >= thr_q);
  assign trip    = samp_valid & reached & shen_q;

  always_comb begin
    shut_d = shut_q | trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
    end else begin
      shut_q <= shut_d;
    end
  end

  assign shutdown_req = shut_q;

endmodule

// File: rtl/thermreg_guard.sv
module thermreg_guard
  import thermreg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned TEMP_W     = 10,
  parameter int unsigned TRUSTED_ID = 0,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              samp_valid,
  input  logic [TEMP_W-1:0] samp_value,
  output logic              shutdown_req
);

  localparam int unsigned PAD_THR = DATA_W - TEMP_W;
  localparam int unsigned PAD_BIT = DATA_W - 1;

  logic              rst_sync_n;
  acc_dec_t          dec;
  logic [TEMP_W-1:0] thr_q;
  logic              shen_q;
  logic              lock_q;

  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_err_q,   rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  thermreg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  thermreg_decode #(
    .ADDR_W     (ADDR_W),
    .ID_W       (ID_W),
    .TRUSTED_ID (TRUSTED_ID)
  ) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_id    (req_id),
    .lock_q    (lock_q),
    .dec       (dec)
  );

  thermreg_regs #(.TEMP_W(TEMP_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dec     (dec),
    .wr_thr  (req_wdata[TEMP_W-1:0]),
    .wr_bit0 (req_wdata[0]),
    .thr_q   (thr_q),
    .shen_q  (shen_q),
    .lock_q  (lock_q)
  );

  thermreg_cmp #(.TEMP_W(TEMP_W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .samp_valid   (samp_valid),
    .samp_value   (samp_value),
    .thr_q        (thr_q),
    .shen_q       (shen_q),
    .shutdown_req (shutdown_req)
  );

  // Response next-state: reads return the pre-edge register value
  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = dec.err;
    rsp_rdata_d = '0;
    if (req_valid && !req_write && !dec.err) begin
      unique case (dec.sel)
        SEL_THR:  rsp_rdata_d = {{PAD_THR{1'b0}}, thr_q};
        SEL_SHEN: rsp_rdata_d = {{PAD_BIT{1'b0}}, shen_q};
        SEL_LOCK: rsp_rdata_d = {{PAD_BIT{1'b0}}, lock_q};
        default:  rsp_rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/thermreg_guard_chk.sv
module thermreg_guard_chk #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned TEMP_W = 10
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ID_W-1:0]   req_id,
  input logic              rsp_valid,
  input logic              samp_valid,
  input logic [TEMP_W-1:0] samp_value,
  input logic [TEMP_W-1:0] thr_q,
  input logic              shen_q,
  input logic              lock_q,
  input logic              shutdown_req
);

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> lock_q);

  a_r3_thr_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> $stable(thr_q));

  a_r3_shen_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lock_q |=> $stable(shen_q));

  a_r4_untrusted_no_lock: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!lock_q && req_valid && req_write && req_id != '0) |=> !lock_q);

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  a_r10_no_extra_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  a_r7_trip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (samp_valid && samp_value >= thr_q && shen_q) |=> shutdown_req);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!shutdown_req && !samp_valid) |=> !shutdown_req);

  a_r9_shut_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shutdown_req |=> shutdown_req);

endmodule

bind thermreg_guard thermreg_guard_chk #(.ID_W(ID_W), .TEMP_W(TEMP_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_id       (req_id),
  .rsp_valid    (rsp_valid),
  .samp_valid   (samp_valid),
  .samp_value   (samp_value),
  .thr_q        (thr_q),
  .shen_q       (shen_q),
  .lock_q       (lock_q),
  .shutdown_req (shutdown_req)
);

// File: tb/thermreg_guard_tb_top.sv
`timescale 1ns/1ps
module thermreg_guard_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_id;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        samp_valid;
  logic [9:0]  samp_value;
  logic        shutdown_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  thermreg_guard dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_id (req_id),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
    .samp_valid (samp_valid), .samp_value (samp_value),
    .shutdown_req (shutdown_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    req_id = 0; samp_valid = 0; samp_value = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Drives one access at a negedge; response is sampled at the next negedge
  task automatic bus(input logic wr, input logic [3:0] addr, input logic [31:0] wd,
                     input logic [3:0] id, output logic [31:0] rd, output logic err,
                     output logic vld);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd; req_id = id;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; err = rsp_err; vld = rsp_valid;
  endtask

  task automatic wr_chk(input string req, input logic [3:0] addr, input logic [31:0] wd,
                        input logic [3:0] id, input logic exp_err);
    logic [31:0] rd; logic err; logic vld;
    bus(1'b1, addr, wd, id, rd, err, vld);
    check({req, " wr rsp_valid"}, {31'd0, vld}, 32'd1);
    check({req, " wr rsp_err"}, {31'd0, err}, {31'd0, exp_err});
  endtask

  task automatic rd_chk(input string req, input logic [3:0] addr, input logic [3:0] id,
                        input logic [31:0] exp_data, input logic exp_err);
    logic [31:0] rd; logic err; logic vld;
    bus(1'b0, addr, 32'd0, id, rd, err, vld);
    check({req, " rd rsp_valid"}, {31'd0, vld}, 32'd1);
    check({req, " rd data"}, rd, exp_data);
    check({req, " rd rsp_err"}, {31'd0, err}, {31'd0, exp_err});
  endtask

  task automatic sample(input logic vld, input logic [9:0] val);
    samp_valid = vld; samp_value = val;
    @(negedge clk);
    samp_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 shutdown", {31'd0, shutdown_req}, 32'd0);
    check("R10 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rd_chk("R1 thr", 4'h0, 4'd0, 32'h3FF, 0);
    rd_chk("R1 shen", 4'h4, 4'd0, 32'd1, 0);
    rd_chk("R1 lock", 4'h8, 4'd0, 32'd0, 0);
  endtask

  task automatic t_unlocked_writes();
    wr_chk("R2 thr by id5", 4'h0, 32'hFFFF_F123, 4'd5, 0);
    rd_chk("R2 thr", 4'h0, 4'd9, 32'h123, 0);
    wr_chk("R2 shen by id0", 4'h4, 32'd0, 4'd0, 0);
    rd_chk("R2 shen", 4'h4, 4'd7, 32'd0, 0);
    wr_chk("R2 shen by id3", 4'h4, 32'd1, 4'd3, 0);
    rd_chk("R10 shen by id15", 4'h4, 4'd15, 32'd1, 0);
  endtask

  task automatic t_compare();
    wr_chk("R2 thr 0x200", 4'h0, 32'h200, 4'd0, 0);
    sample(1'b1, 10'h1FF);
    check("R8 below", {31'd0, shutdown_req}, 32'd0);
    sample(1'b0, 10'h3FF);
    check("R8 no strobe", {31'd0, shutdown_req}, 32'd0);
    wr_chk("R2 shen off", 4'h4, 32'd0, 4'd0, 0);
    sample(1'b1, 10'h3FF);
    check("R8 enable off", {31'd0, shutdown_req}, 32'd0);
    wr_chk("R2 shen on", 4'h4, 32'd1, 4'd0, 0);
    sample(1'b1, 10'h200);
    check("R7 equal trips", {31'd0, shutdown_req}, 32'd1);
    sample(1'b1, 10'h000);
    sample(1'b1, 10'h010);
    check("R9 sticky after low", {31'd0, shutdown_req}, 32'd1);
    wr_chk("R9 shen off", 4'h4, 32'd0, 4'd0, 0);
    check("R9 sticky after disable", {31'd0, shutdown_req}, 32'd1);
  endtask

  task automatic t_reset_value_trip();
    do_reset();
    sample(1'b1, 10'h3FE);
    check("R8 below reset thr", {31'd0, shutdown_req}, 32'd0);
    sample(1'b1, 10'h3FF);
    check("R7 trip at reset thr", {31'd0, shutdown_req}, 32'd1);
  endtask

  task automatic t_lock();
    do_reset();
    wr_chk("R2 thr 0x155", 4'h0, 32'h155, 4'd0, 0);
    wr_chk("R4 untrusted lock", 4'h8, 32'd1, 4'd6, 1);
    rd_chk("R4 lock still 0", 4'h8, 4'd0, 32'd0, 0);
    wr_chk("R5 write 0", 4'h8, 32'd0, 4'd0, 0);
    rd_chk("R5 lock still 0", 4'h8, 4'd0, 32'd0, 0);
    wr_chk("R5 set", 4'h8, 32'd1, 4'd0, 0);
    rd_chk("R5 lock 1", 4'h8, 4'd2, 32'd1, 0);
    wr_chk("R3 thr id0", 4'h0, 32'h0AA, 4'd0, 1);
    wr_chk("R3 thr id3", 4'h0, 32'h0AA, 4'd3, 1);
    rd_chk("R3 thr held", 4'h0, 4'd3, 32'h155, 0);
    wr_chk("R3 shen id0", 4'h4, 32'd0, 4'd0, 1);
    wr_chk("R3 shen id8", 4'h4, 32'd0, 4'd8, 1);
    rd_chk("R3 shen held", 4'h4, 4'd8, 32'd1, 0);
    wr_chk("R6 clr id0", 4'h8, 32'd0, 4'd0, 0);
    wr_chk("R6 clr id2", 4'h8, 32'd0, 4'd2, 1);
    wr_chk("R6 w1 id2", 4'h8, 32'hFFFF_FFFE, 4'd2, 1);
    rd_chk("R6 lock held", 4'h8, 4'd1, 32'd1, 0);
    sample(1'b1, 10'h155);
    check("R7 trip while locked", {31'd0, shutdown_req}, 32'd1);
    do_reset();
    rd_chk("R6 reset clears", 4'h8, 4'd0, 32'd0, 0);
  endtask

  task automatic t_unmapped();
    wr_chk("R11 wr 0xC", 4'hC, 32'h1, 4'd0, 1);
    wr_chk("R11 wr 0x1", 4'h1, 32'h0, 4'd0, 1);
    wr_chk("R11 wr 0x9", 4'h9, 32'h1, 4'd0, 1);
    rd_chk("R11 rd 0xC", 4'hC, 4'd0, 32'd0, 1);
    rd_chk("R11 rd 0x2", 4'h2, 4'd4, 32'd0, 1);
    rd_chk("R11 thr kept", 4'h0, 4'd0, 32'h3FF, 0);
    rd_chk("R11 shen kept", 4'h4, 4'd0, 32'd1, 0);
    rd_chk("R11 lock kept", 4'h8, 4'd0, 32'd0, 0);
    @(negedge clk);
    check("R10 single rsp", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_unlocked_writes();
    t_compare();
    t_reset_value_trip();
    t_lock();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule